// File: doc/BRIEF.md
# Flash Command Header Packer

This block takes one serial-flash operation, described by its opcode, address length, address, dummy byte count, data byte count, data lane count and direction. It produces the eight-byte header that a shift engine sends ahead of the data, packed into two 32-bit words. It also produces the number of clock cycles the engine spends on the command phase, on transmit and on receive. The opcode, address and dummy phases always use one lane. The data phase uses one lane or four.

A request strobe loads the inputs. One cycle later the registered results appear together with a one-cycle valid pulse, and they hold until the next strobe. An operation the engine cannot perform gives an error flag, an all-zero header and zero cycle counts. This happens for an address length other than zero, three or four bytes, and for a data lane count other than one or four.

Top module: `flash_hdr_packer`

## Requirements
- R1: `valid_o` is high in exactly the cycle after each cycle in which `req_i` is high. All other outputs change only on a clock edge where `req_i` is high. Input changes while `req_i` is low have no effect on them.
- R2: For every accepted operation, the opcode sits in header byte 3, which is `hdr_w0_o[31:24]`. Header byte k is `hdr_w0_o[8k+7:8k]` for k below 4, and `hdr_w1_o[8(k-4)+7:8(k-4)]` for k from 4 to 7.
- R3: Address length code 0 means no address. Byte 2 is 0xFF, bytes 0, 1 and 4 to 7 are zero, and the command count is 8 + 8 × dummy bytes.
- R4: Address length code 3 means a 3-byte address. Bytes 2, 1 and 0 carry address bits [23:16], [15:8] and [7:0]. Bytes 6 and 7 are 0xFF, bytes 4 and 5 are zero, and the command count is 32 + 8 × dummy bytes.
- R5: Address length code 4 means a 4-byte address. Bytes 2, 1 and 0 carry address bits [31:24], [23:16] and [15:8]. Byte 6 is 0xFF, byte 5 is zero, and the command count is 40 + 8 × dummy bytes.
- R6: With a 4-byte address, address bits [7:0] go to byte 7 and byte 4 is zero when the dummy count is non-zero. With no dummy bytes they go to byte 4 and byte 7 is zero.
- R7: Any address length code other than 0, 3 or 4 sets `err_o`. Both header words and all three cycle counts are then zero.
- R8: A data lane count other than 1 or 4 sets `err_o`, with an all-zero header and zero cycle counts.
- R9: The data cycle count is 8 × data bytes on one lane and 2 × data bytes on four lanes.
- R10: A write (`dir_rd_i` = 0) gives transmit = command + data cycles and receive = 0. A read gives transmit = command cycles and receive = data cycles.
- R11: After reset, `valid_o` and `err_o` are low, and both header words and all cycle counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, loads the operation |
| opcode_i | input | 8 | Command opcode |
| addr_len_i | input | 3 | Address length in bytes (0, 3 or 4 accepted) |
| addr_i | input | 32 | Address value |
| dummy_bytes_i | input | DUMMY_W (3) | Number of dummy bytes |
| data_bytes_i | input | LEN_W (16) | Number of data bytes |
| data_lanes_i | input | 3 | Data lane count (1 or 4 accepted) |
| dir_rd_i | input | 1 | 1 = read, 0 = write or no data |
| valid_o | output | 1 | Result pulse, one cycle after the request |
| err_o | output | 1 | Operation rejected |
| hdr_w0_o | output | 32 | Header bytes 3..0 |
| hdr_w1_o | output | 32 | Header bytes 7..4 |
| cmd_cyc_o | output | LEN_W+4 (20) | Command phase cycles |
| tx_cyc_o | output | LEN_W+4 (20) | Transmit cycles |
| rx_cyc_o | output | LEN_W+4 (20) | Receive cycles |

## Verification
The hardest case to reach is the 4-byte address. There, the lowest address byte moves between two slots depending on the dummy count, and each operation also passes through the read and write cycle rules. Random stimulus spreads address lengths, dummy counts and directions evenly. Directed vectors then pin the 4-byte case with zero and non-zero dummy counts against the largest data count and the zero data count. After every request, the bench spends a cycle driving random inputs with the strobe low, to show that the registered results do not move.

// File: rtl/fhp_pkg.sv
package fhp_pkg;
   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam logic [2:0] ALEN_NONE = 3'd0;
   localparam logic [2:0] ALEN_THREE = 3'd3;
   localparam logic [2:0] ALEN_FOUR = 3'd4;
   localparam logic [2:0] LANES_ONE = 3'd1;
   localparam logic [2:0] LANES_FOUR = 3'd4;
   localparam int HDR_BYTES = 8;
   typedef logic [7:0] hbyte_t;
endpackage

// File: rtl/fhp_hdr_layout.sv
module fhp_hdr_layout
   import fhp_pkg::*;
(
   input  logic [7:0]  opcode,
   input  logic [2:0]  addr_len,
   input  logic [31:0] addr,
   input  logic        has_dummy,
   output logic        len_ok,
   output logic [8*HDR_BYTES-1:0] hdr
);
   function automatic hbyte_t lane_val(input int idx, input logic [7:0] op,
                                       input logic [2:0] alen, input logic [31:0] a,
                                       input logic dum);
      hbyte_t v;
      v = '0;
      case (idx)
         3: v = op;
         2: v = (alen == ALEN_NONE) ? FILL_BYTE :
                (alen == ALEN_THREE) ? a[23:16] : a[31:24];
         1: v = (alen == ALEN_THREE) ? a[15:8] :
                (alen == ALEN_FOUR) ? a[23:16] : 8'h00;
         0: v = (alen == ALEN_THREE) ? a[7:0] :
                (alen == ALEN_FOUR) ? a[15:8] : 8'h00;
         4: v = (alen == ALEN_FOUR && !dum) ? a[7:0] : 8'h00;
         5: v = 8'h00;
         6: v = (alen == ALEN_NONE) ? 8'h00 : FILL_BYTE;
         7: v = (alen == ALEN_THREE) ? FILL_BYTE :
                (alen == ALEN_FOUR && dum) ? a[7:0] : 8'h00;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   assign len_ok = (addr_len == ALEN_NONE) || (addr_len == ALEN_THREE) ||
                   (addr_len == ALEN_FOUR);

   for (genvar b = 0; b < HDR_BYTES; b++) begin : g_lane
      assign hdr[b*8 +: 8] = len_ok ? lane_val(b, opcode, addr_len, addr, has_dummy) : 8'h00;
   end
endmodule

// File: rtl/fhp_cycle_calc.sv
module fhp_cycle_calc
   import fhp_pkg::*;
#(
   parameter int DUMMY_W = 3,
   parameter int LEN_W = 16,
   parameter bit QUAD_EN = 1'b1,
   parameter int CYC_W = LEN_W + 4
) (
   input  logic [2:0]         addr_len,
   input  logic [DUMMY_W-1:0] dummy_bytes,
   input  logic [LEN_W-1:0]   data_bytes,
   input  logic [2:0]         data_lanes,
   input  logic               dir_rd,
   output logic               lanes_ok,
   output logic [CYC_W-1:0]   cmd_cyc,
   output logic [CYC_W-1:0]   tx_cyc,
   output logic [CYC_W-1:0]   rx_cyc
);
   logic [CYC_W-1:0] base_cyc;
   logic [CYC_W-1:0] dummy_cyc;
   logic [CYC_W-1:0] data_cyc;
   logic [CYC_W-1:0] data_x8;

   assign data_x8 = CYC_W'(data_bytes) << 3;

   if (QUAD_EN) begin : g_quad
      assign lanes_ok = (data_lanes == LANES_ONE) || (data_lanes == LANES_FOUR);
      assign data_cyc = (data_lanes == LANES_FOUR) ? (CYC_W'(data_bytes) << 1) : data_x8;
   end else begin : g_single
      assign lanes_ok = (data_lanes == LANES_ONE);
      assign data_cyc = data_x8;
   end

   always_comb begin
      case (addr_len)
         ALEN_THREE: base_cyc = CYC_W'(32);
         ALEN_FOUR:  base_cyc = CYC_W'(40);
         default:    base_cyc = CYC_W'(8);
      endcase
   end

   assign dummy_cyc = CYC_W'(dummy_bytes) << 3;
   assign cmd_cyc = base_cyc + dummy_cyc;
   assign tx_cyc = dir_rd ? cmd_cyc : (cmd_cyc + data_cyc);
   assign rx_cyc = dir_rd ? data_cyc : '0;
endmodule

// File: rtl/flash_hdr_packer.sv
module flash_hdr_packer
   import fhp_pkg::*;
#(
   parameter int DUMMY_W = 3,
   parameter int LEN_W = 16,
   parameter bit QUAD_EN = 1'b1,
   localparam int CYC_W = LEN_W + 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic [7:0]         opcode_i,
   input  logic [2:0]         addr_len_i,
   input  logic [31:0]        addr_i,
   input  logic [DUMMY_W-1:0] dummy_bytes_i,
   input  logic [LEN_W-1:0]   data_bytes_i,
   input  logic [2:0]         data_lanes_i,
   input  logic               dir_rd_i,
   output logic               valid_o,
   output logic               err_o,
   output logic [31:0]        hdr_w0_o,
   output logic [31:0]        hdr_w1_o,
   output logic [CYC_W-1:0]   cmd_cyc_o,
   output logic [CYC_W-1:0]   tx_cyc_o,
   output logic [CYC_W-1:0]   rx_cyc_o
);
   if (DUMMY_W < 1 || DUMMY_W > 5) begin : g_bad_dummy_w
      $error("DUMMY_W must lie in 1..5");
   end
   if (LEN_W < 4 || LEN_W > 24) begin : g_bad_len_w
      $error("LEN_W must lie in 4..24");
   end

   logic        len_ok;
   logic        lanes_ok;
   logic        op_ok;
   logic [63:0] hdr_c;
   logic [CYC_W-1:0] cmd_c, tx_c, rx_c;

   fhp_hdr_layout u_layout (
      .opcode    (opcode_i),
      .addr_len  (addr_len_i),
      .addr      (addr_i),
      .has_dummy (|dummy_bytes_i),
      .len_ok    (len_ok),
      .hdr       (hdr_c)
   );

   fhp_cycle_calc #(
      .DUMMY_W (DUMMY_W),
      .LEN_W   (LEN_W),
      .QUAD_EN (QUAD_EN),
      .CYC_W   (CYC_W)
   ) u_cycles (
      .addr_len    (addr_len_i),
      .dummy_bytes (dummy_bytes_i),
      .data_bytes  (data_bytes_i),
      .data_lanes  (data_lanes_i),
      .dir_rd      (dir_rd_i),
      .lanes_ok    (lanes_ok),
      .cmd_cyc     (cmd_c),
      .tx_cyc      (tx_c),
      .rx_cyc      (rx_c)
   );

   assign op_ok = len_ok && lanes_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         err_o     <= 1'b0;
         hdr_w0_o  <= '0;
         hdr_w1_o  <= '0;
         cmd_cyc_o <= '0;
         tx_cyc_o  <= '0;
         rx_cyc_o  <= '0;
      end else begin
         valid_o <= req_i;
         if (req_i) begin
            err_o     <= !op_ok;
            hdr_w0_o  <= op_ok ? hdr_c[31:0] : '0;
            hdr_w1_o  <= op_ok ? hdr_c[63:32] : '0;
            cmd_cyc_o <= op_ok ? cmd_c : '0;
            tx_cyc_o  <= op_ok ? tx_c : '0;
            rx_cyc_o  <= op_ok ? rx_c : '0;
         end
      end
   end
endmodule

// File: rtl/fhp_checker.sv
module fhp_checker #(
   parameter int CYC_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic [7:0]       opcode_i,
   input logic [2:0]       addr_len_i,
   input logic             dir_rd_i,
   input logic             valid_o,
   input logic             err_o,
   input logic [31:0]      hdr_w0_o,
   input logic [31:0]      hdr_w1_o,
   input logic [CYC_W-1:0] cmd_cyc_o,
   input logic [CYC_W-1:0] tx_cyc_o,
   input logic [CYC_W-1:0] rx_cyc_o
);
   p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> valid_o);
   p_valid_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(req_i));
   p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> ($stable(hdr_w0_o) && $stable(hdr_w1_o) && $stable(tx_cyc_o) &&
                  $stable(rx_cyc_o) && $stable(err_o)));
   p_opcode_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !err_o) |-> hdr_w0_o[31:24] == $past(opcode_i));
   p_bad_len_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && addr_len_i != 3'd0 && addr_len_i != 3'd3 && addr_len_i != 3'd4) |=> err_o);
   p_err_zeroes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (cmd_cyc_o == '0 && tx_cyc_o == '0 && rx_cyc_o == '0 &&
                 hdr_w0_o == '0 && hdr_w1_o == '0));
   p_write_no_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(dir_rd_i)) |-> rx_cyc_o == '0);
   p_read_tx_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !err_o && $past(dir_rd_i)) |-> tx_cyc_o == cmd_cyc_o);
endmodule

bind flash_hdr_packer fhp_checker #(.CYC_W(CYC_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .opcode_i   (opcode_i),
   .addr_len_i (addr_len_i),
   .dir_rd_i   (dir_rd_i),
   .valid_o    (valid_o),
   .err_o      (err_o),
   .hdr_w0_o   (hdr_w0_o),
   .hdr_w1_o   (hdr_w1_o),
   .cmd_cyc_o  (cmd_cyc_o),
   .tx_cyc_o   (tx_cyc_o),
   .rx_cyc_o   (rx_cyc_o)
);

// File: tb/flash_hdr_packer_tb_top.sv
module flash_hdr_packer_tb_top;
   localparam int DW = 3;
   localparam int LW = 16;
   localparam int CW = LW + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0;
   logic [7:0] opcode_i = '0;
   logic [2:0] addr_len_i = '0;
   logic [31:0] addr_i = '0;
   logic [DW-1:0] dummy_bytes_i = '0;
   logic [LW-1:0] data_bytes_i = '0;
   logic [2:0] data_lanes_i = 3'd1;
   logic dir_rd_i = 1'b0;
   logic valid_o, err_o;
   logic [31:0] hdr_w0_o, hdr_w1_o;
   logic [CW-1:0] cmd_cyc_o, tx_cyc_o, rx_cyc_o;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   flash_hdr_packer #(.DUMMY_W(DW), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .opcode_i(opcode_i),
      .addr_len_i(addr_len_i), .addr_i(addr_i), .dummy_bytes_i(dummy_bytes_i),
      .data_bytes_i(data_bytes_i), .data_lanes_i(data_lanes_i), .dir_rd_i(dir_rd_i),
      .valid_o(valid_o), .err_o(err_o), .hdr_w0_o(hdr_w0_o), .hdr_w1_o(hdr_w1_o),
      .cmd_cyc_o(cmd_cyc_o), .tx_cyc_o(tx_cyc_o), .rx_cyc_o(rx_cyc_o)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_hdr(input logic [7:0] op, input logic [2:0] al,
                                           input logic [31:0] a, input int dum);
      logic [7:0] b [8];
      for (int i = 0; i < 8; i++) b[i] = 8'h00;
      b[3] = op;
      if (al == 3'd0) begin
         b[2] = 8'hFF;
      end else if (al == 3'd3) begin
         b[2] = a[23:16]; b[1] = a[15:8]; b[0] = a[7:0];
         b[7] = 8'hFF; b[6] = 8'hFF;
      end else begin
         b[2] = a[31:24]; b[1] = a[23:16]; b[0] = a[15:8];
         b[6] = 8'hFF;
         if (dum != 0) b[7] = a[7:0]; else b[4] = a[7:0];
      end
      return {b[7], b[6], b[5], b[4], b[3], b[2], b[1], b[0]};
   endfunction

   function automatic int exp_cmd(input logic [2:0] al, input int dum);
      int base;
      base = (al == 3'd0) ? 8 : (al == 3'd3) ? 32 : 40;
      return base + 8 * dum;
   endfunction

   function automatic string len_tag(input logic [2:0] al, input int dum);
      if (al == 3'd0) return "R3";
      if (al == 3'd3) return "R4";
      return (dum != 0) ? "R6" : "R5";
   endfunction

   task automatic apply(input logic [7:0] op, input logic [2:0] al, input logic [31:0] a,
                        input int dum, input int nb, input logic [2:0] ln, input logic rd);
      logic [63:0] hsave;
      logic [CW-1:0] tsave, rsave;
      bit len_ok, ln_ok;
      int dcyc, ccyc;
      @(negedge clk);
      opcode_i = op; addr_len_i = al; addr_i = a; dummy_bytes_i = DW'(dum);
      data_bytes_i = LW'(nb); data_lanes_i = ln; dir_rd_i = rd; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      opcode_i = 8'($urandom); addr_len_i = 3'($urandom); addr_i = $urandom;
      dummy_bytes_i = DW'($urandom); data_bytes_i = LW'($urandom);
      data_lanes_i = 3'($urandom); dir_rd_i = 1'($urandom);
      len_ok = (al == 3'd0 || al == 3'd3 || al == 3'd4);
      ln_ok = (ln == 3'd1 || ln == 3'd4);
      check("R1", "valid after req", 64'(valid_o), 64'd1);
      if (!len_ok) begin
         check("R7", "err bad len", 64'(err_o), 64'd1);
         check("R7", "hdr zero", {hdr_w1_o, hdr_w0_o}, 64'd0);
         check("R7", "counts zero", 64'({cmd_cyc_o, tx_cyc_o, rx_cyc_o}), 64'd0);
      end else if (!ln_ok) begin
         check("R8", "err bad lanes", 64'(err_o), 64'd1);
         check("R8", "hdr zero", {hdr_w1_o, hdr_w0_o}, 64'd0);
         check("R8", "counts zero", 64'({cmd_cyc_o, tx_cyc_o, rx_cyc_o}), 64'd0);
      end else begin
         dcyc = (ln == 3'd4) ? nb * 2 : nb * 8;
         ccyc = exp_cmd(al, dum);
         check("R7", "no err", 64'(err_o), 64'd0);
         check("R2", "opcode slot", 64'(hdr_w0_o[31:24]), 64'(op));
         check(len_tag(al, dum), "header", {hdr_w1_o, hdr_w0_o}, exp_hdr(op, al, a, dum));
         check(len_tag(al, dum), "cmd cycles", 64'(cmd_cyc_o), 64'(ccyc));
         check("R9", "data cycles", rd ? 64'(rx_cyc_o) : 64'(tx_cyc_o - cmd_cyc_o), 64'(dcyc));
         check("R10", "tx cycles", 64'(tx_cyc_o), rd ? 64'(ccyc) : 64'(ccyc + dcyc));
         check("R10", "rx cycles", 64'(rx_cyc_o), rd ? 64'(dcyc) : 64'd0);
      end
      hsave = {hdr_w1_o, hdr_w0_o}; tsave = tx_cyc_o; rsave = rx_cyc_o;
      @(negedge clk);
      check("R1", "valid low when idle", 64'(valid_o), 64'd0);
      check("R1", "header holds", {hdr_w1_o, hdr_w0_o}, hsave);
      check("R1", "counts hold", 64'({tx_cyc_o, rsave}), 64'({tsave, rx_cyc_o}));
   endtask

   initial begin
      #(1_000_000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R11", "reset valid", 64'(valid_o), 64'd0);
      check("R11", "reset err", 64'(err_o), 64'd0);
      check("R11", "reset hdr", {hdr_w1_o, hdr_w0_o}, 64'd0);
      check("R11", "reset counts", 64'({cmd_cyc_o, tx_cyc_o, rx_cyc_o}), 64'd0);
      rst_n = 1'b1;
      // directed corners
      apply(8'h9F, 3'd0, 32'h0, 0, 4, 3'd1, 1'b1);
      apply(8'h0B, 3'd0, 32'h0, 1, 0, 3'd1, 1'b0);
      apply(8'h03, 3'd3, 32'hAB123456, 0, 256, 3'd1, 1'b1);
      apply(8'h6B, 3'd3, 32'h00654321, 7, 65535, 3'd4, 1'b1);
      apply(8'h13, 3'd4, 32'hDEADBEEF, 0, 100, 3'd4, 1'b1);
      apply(8'h6C, 3'd4, 32'h01234567, 1, 65535, 3'd4, 1'b0);
      apply(8'h12, 3'd4, 32'hCAFEF00D, 0, 0, 3'd1, 1'b0);
      apply(8'hEC, 3'd4, 32'h89ABCDEF, 7, 65535, 3'd1, 1'b1);
      for (int al = 0; al < 8; al++) apply(8'h55, 3'(al), 32'h11223344, 2, 8, 3'd1, 1'b0);
      for (int ln = 0; ln < 8; ln++) apply(8'hA5, 3'd3, 32'h778899AA, 1, 16, 3'(ln), 1'b1);
      // random mix
      for (int k = 0; k < 400; k++) begin
         logic [2:0] al;
         logic [2:0] ln;
         int sel;
         sel = int'($urandom % 10);
         al = (sel < 3) ? 3'd0 : (sel < 6) ? 3'd3 : (sel < 9) ? 3'd4 : 3'($urandom);
         sel = int'($urandom % 10);
         ln = (sel < 4) ? 3'd1 : (sel < 9) ? 3'd4 : 3'($urandom);
         apply(8'($urandom), al, $urandom, int'($urandom % 8), int'($urandom % 65536),
               ln, 1'($urandom));
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule